// File: doc/BRIEF.md
# Debug Test Access Port with Instruction Decode and Bypass

This block is the scan-clock side of a debug port. A host drives TCK, TMS, TDI and an active-low TRST. It moves a 16-state test controller through its states, shifts a 16-bit instruction into the block and shifts data through either a one-bit bypass stage or an external boundary register. The 4-bit code in the top of the instruction register chooses the data path. Some codes also drive debug side-band signals to the core: a debug reset level, a debug interrupt pulse and a wake-from-sleep pulse.

The controller state register advances on the rising edge of TCK. The instruction shift register and the bypass stage also move on the rising edge. The instruction register, the side-band outputs and TDO change on the falling edge. The boundary register is outside this block. The block gives it a select line, a mode line and capture, shift and update strobes, and takes back its serial output. Nothing on the core side can write the instruction register.

Controller states and their successors, written as (TMS=0 / TMS=1):
- Test-Logic-Reset: (Run-Test/Idle / Test-Logic-Reset)
- Run-Test/Idle: (Run-Test/Idle / Select-DR)
- Select-DR: (Capture-DR / Select-IR)
- Capture-DR: (Shift-DR / Exit1-DR)
- Shift-DR: (Shift-DR / Exit1-DR)
- Exit1-DR: (Pause-DR / Update-DR)
- Pause-DR: (Pause-DR / Exit2-DR)
- Exit2-DR: (Shift-DR / Update-DR)
- Update-DR: (Run-Test/Idle / Select-DR)
- Select-IR: (Capture-IR / Test-Logic-Reset)
- Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR: the same as their DR counterparts.

Top module: `dbg_tap_unit`

## Requirements
- R1: The controller follows the state list above on each rising TCK edge. Five rising edges with TMS high reach Test-Logic-Reset from any state. TRST low forces Test-Logic-Reset at once.
- R2: In Capture-IR the instruction shift register loads {current code, ten ones, 2'b01}, with bit 0 = 1 and bit 1 = 0. Shift-IR shifts TDI in at bit 15 and presents bit 0 on TDO, least significant bit first.
- R3: On the falling TCK edge in Update-IR, the code (instruction bits 15:12) becomes the last four bits shifted in. The code returns to 1111 when TRST is low or at a falling edge in Test-Logic-Reset.
- R4: For every code except 0000 and 0100, the DR path is the bypass stage. It loads 0 in Capture-DR, so TDO gives 0 first and then TDI delayed by one TCK.
- R5: Codes 0000 and 0100 select the boundary register. bsr_sel_o is high, TDO in Shift-DR follows bsr_so_i, and the capture, shift and update strobes are high in their DR states. bsr_extest_o is high only for 0000.
- R6: Code 0111 sets dbg_rst_o and code 0110 clears it. The level holds through all other codes and through Test-Logic-Reset. TRST low clears it.
- R7: Codes 1010 and 1011 raise dbg_irq_o for exactly one TCK period, starting at the falling edge in Update-IR.
- R8: Code 0001 raises wake_o for exactly one TCK period, starting at the falling edge in Update-IR.
- R9: The reserved codes 0101, 1000, 1001, 1100, 1101 and 1110 leave dbg_rst_o, dbg_irq_o and wake_o unchanged. They use the bypass path.
- R10: TDO and tdo_oe change on falling TCK edges. tdo_oe is high only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| bsr_so_i | input | 1 | Serial output of the external boundary register |
| bsr_sel_o | output | 1 | Boundary register is the selected DR path |
| bsr_extest_o | output | 1 | Boundary register drives the pins (code 0000) |
| bsr_capture_o | output | 1 | Boundary capture strobe |
| bsr_shift_o | output | 1 | Boundary shift strobe |
| bsr_update_o | output | 1 | Boundary update strobe |
| dbg_rst_o | output | 1 | Debug reset level to the core |
| dbg_irq_o | output | 1 | Debug interrupt pulse |
| wake_o | output | 1 | Wake-from-sleep pulse |

## Verification
A wrong controller state shows within one falling edge as a misplaced tdo_oe. It also shows as a capture word shifted out one bit early or late. A corrupt instruction code shows in the next Capture-IR, because the code is shifted back out in bits 15:12. It also shows at once in the boundary select lines and in the bypass-versus-boundary TDO pattern. A side-band decode error shows as a pulse at the Update-IR falling edge that is missing, extra or too long, or as a reset level that changes after a reserved code or after Test-Logic-Reset.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPD
    } tap_state_e;

    typedef enum logic [3:0] {
        OPC_EXTEST,
        OPC_SAMPLE,
        OPC_RST_ON,
        OPC_RST_OFF,
        OPC_IRQ,
        OPC_WAKE,
        OPC_BYPASS,
        OPC_RSVD
    } op_class_e;

    function automatic op_class_e classify(input logic [CODE_W-1:0] c);
        op_class_e r;
        casez (c)
            4'b0000: r = OPC_EXTEST;
            4'b0100: r = OPC_SAMPLE;
            4'b0111: r = OPC_RST_ON;
            4'b0110: r = OPC_RST_OFF;
            4'b101?: r = OPC_IRQ;
            4'b0001: r = OPC_WAKE;
            4'b1111: r = OPC_BYPASS;
            default: r = OPC_RSVD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output logic in_reset_o,
    output logic dr_cap_o,
    output logic dr_shift_o,
    output logic dr_upd_o,
    output logic ir_cap_o,
    output logic ir_shift_o,
    output logic ir_upd_o
);

    tap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            default:     state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    always_comb begin
        in_reset_o = 1'b0;
        dr_cap_o   = 1'b0;
        dr_shift_o = 1'b0;
        dr_upd_o   = 1'b0;
        ir_cap_o   = 1'b0;
        ir_shift_o = 1'b0;
        ir_upd_o   = 1'b0;
        unique case (state_q)
            ST_RESET:    in_reset_o = 1'b1;
            ST_DR_CAP:   dr_cap_o   = 1'b1;
            ST_DR_SHIFT: dr_shift_o = 1'b1;
            ST_DR_UPD:   dr_upd_o   = 1'b1;
            ST_IR_CAP:   ir_cap_o   = 1'b1;
            ST_IR_SHIFT: ir_shift_o = 1'b1;
            ST_IR_UPD:   ir_upd_o   = 1'b1;
            default:     ;
        endcase
    end

    assert_tlr_hold_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET && tms) |=> state_q == ST_RESET);

    assert_sel_ir_escape_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_IR_SEL && tms) |=> state_q == ST_RESET);

    assert_upd_ir_next_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_IR_UPD && !tms) |=> state_q == ST_IDLE);

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
    import dbg_tap_pkg::*;
#(
    parameter int IR_W = 16
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              in_reset,
    input  logic              ir_cap,
    input  logic              ir_shift,
    input  logic              ir_upd,
    input  logic              tdi,
    output logic              sr_lsb_o,
    output logic [CODE_W-1:0] load_code_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int FILL_W = IR_W - CODE_W - 2;
    localparam logic [CODE_W-1:0] CODE_INIT = '1;

    logic [IR_W-1:0] sr_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= '1;
        end else if (ir_cap) begin
            sr_q <= {code_o, {FILL_W{1'b1}}, 2'b01};
        end else if (ir_shift) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    assign sr_lsb_o    = sr_q[0];
    assign load_code_o = sr_q[IR_W-1 -: CODE_W];

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)       code_o <= CODE_INIT;
        else if (in_reset) code_o <= CODE_INIT;
        else if (ir_upd)   code_o <= load_code_o;
    end

    assert_code_reset_R3: assert property (@(negedge tck) disable iff (!trst_n)
        in_reset |=> code_o == CODE_INIT);

    assert_capture_tail_R2: assert property (@(posedge tck) disable iff (!trst_n)
        ir_cap |=> (sr_q[1:0] == 2'b01));

endmodule

// File: rtl/dbg_tap_side.sv
module dbg_tap_side
    import dbg_tap_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              ir_upd,
    input  logic [CODE_W-1:0] load_code,
    output logic              dbg_rst_o,
    output logic              dbg_irq_o,
    output logic              wake_o
);

    op_class_e cls;
    assign cls = classify(load_code);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            dbg_rst_o <= 1'b0;
            dbg_irq_o <= 1'b0;
            wake_o    <= 1'b0;
        end else begin
            dbg_irq_o <= ir_upd && (cls == OPC_IRQ);
            wake_o    <= ir_upd && (cls == OPC_WAKE);
            if (ir_upd && cls == OPC_RST_ON)       dbg_rst_o <= 1'b1;
            else if (ir_upd && cls == OPC_RST_OFF) dbg_rst_o <= 1'b0;
        end
    end

    assert_rst_hold_R6: assert property (@(negedge tck) disable iff (!trst_n)
        !ir_upd |=> $stable(dbg_rst_o));

    assert_irq_pulse_R7: assert property (@(negedge tck) disable iff (!trst_n)
        dbg_irq_o |=> !dbg_irq_o);

    assert_wake_pulse_R8: assert property (@(negedge tck) disable iff (!trst_n)
        wake_o |=> !wake_o);

    assert_rsv_quiet_R9: assert property (@(negedge tck) disable iff (!trst_n)
        (ir_upd && cls == OPC_RSVD) |=> ($stable(dbg_rst_o) && !dbg_irq_o && !wake_o));

endmodule

// File: rtl/dbg_tap_unit.sv
module dbg_tap_unit
    import dbg_tap_pkg::*;
#(
    parameter int IR_W = 16
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    input  logic bsr_so_i,
    output logic bsr_sel_o,
    output logic bsr_extest_o,
    output logic bsr_capture_o,
    output logic bsr_shift_o,
    output logic bsr_update_o,
    output logic dbg_rst_o,
    output logic dbg_irq_o,
    output logic wake_o
);

    logic in_reset, dr_cap, dr_shift, dr_upd, ir_cap, ir_shift, ir_upd;
    logic ir_lsb;
    logic [CODE_W-1:0] load_code, code;
    logic byp_q;
    op_class_e cur_cls;

    dbg_tap_fsm u_fsm (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .in_reset_o (in_reset),
        .dr_cap_o   (dr_cap),
        .dr_shift_o (dr_shift),
        .dr_upd_o   (dr_upd),
        .ir_cap_o   (ir_cap),
        .ir_shift_o (ir_shift),
        .ir_upd_o   (ir_upd)
    );

    dbg_tap_ir #(.IR_W(IR_W)) u_ir (
        .tck         (tck),
        .trst_n      (trst_n),
        .in_reset    (in_reset),
        .ir_cap      (ir_cap),
        .ir_shift    (ir_shift),
        .ir_upd      (ir_upd),
        .tdi         (tdi),
        .sr_lsb_o    (ir_lsb),
        .load_code_o (load_code),
        .code_o      (code)
    );

    dbg_tap_side u_side (
        .tck       (tck),
        .trst_n    (trst_n),
        .ir_upd    (ir_upd),
        .load_code (load_code),
        .dbg_rst_o (dbg_rst_o),
        .dbg_irq_o (dbg_irq_o),
        .wake_o    (wake_o)
    );

    assign cur_cls       = classify(code);
    assign bsr_sel_o     = (cur_cls == OPC_EXTEST) || (cur_cls == OPC_SAMPLE);
    assign bsr_extest_o  = (cur_cls == OPC_EXTEST);
    assign bsr_capture_o = bsr_sel_o && dr_cap;
    assign bsr_shift_o   = bsr_sel_o && dr_shift;
    assign bsr_update_o  = bsr_sel_o && dr_upd;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       byp_q <= 1'b0;
        else if (dr_cap)   byp_q <= 1'b0;
        else if (dr_shift) byp_q <= tdi;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= ir_shift || dr_shift;
            if (ir_shift)       tdo <= ir_lsb;
            else if (bsr_sel_o) tdo <= bsr_so_i;
            else                tdo <= byp_q;
        end
    end

    assert_oe_shift_R10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (ir_shift || dr_shift));

    assert_side_excl_R7: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({dbg_irq_o, wake_o}));

    assert_strobe_sel_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (bsr_capture_o || bsr_shift_o || bsr_update_o) |-> !in_reset);

endmodule

// File: tb/tb_dbg_tap_unit.sv
module tb_dbg_tap_unit;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic bsr_so_i = 1'b0;
    logic tdo, tdo_oe, bsr_sel_o, bsr_extest_o, bsr_capture_o, bsr_shift_o, bsr_update_o;
    logic dbg_rst_o, dbg_irq_o, wake_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 tck = ~tck;

    dbg_tap_unit dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .bsr_so_i(bsr_so_i),
        .bsr_sel_o(bsr_sel_o), .bsr_extest_o(bsr_extest_o),
        .bsr_capture_o(bsr_capture_o), .bsr_shift_o(bsr_shift_o),
        .bsr_update_o(bsr_update_o), .dbg_rst_o(dbg_rst_o),
        .dbg_irq_o(dbg_irq_o), .wake_o(wake_o)
    );

    // Vector fields: [8:5] code, [4] rst level, [3] irq pulse, [2] wake pulse, [1] boundary sel, [0] extest
    localparam logic [8:0] VEC [16] = '{
        {4'b0111, 5'b10000}, {4'b0101, 5'b10000}, {4'b1010, 5'b11000}, {4'b1011, 5'b11000},
        {4'b0110, 5'b00000}, {4'b1000, 5'b00000}, {4'b0111, 5'b10000}, {4'b1100, 5'b10000},
        {4'b1110, 5'b10000}, {4'b0001, 5'b10100}, {4'b0110, 5'b00000}, {4'b0000, 5'b00011},
        {4'b0100, 5'b00010}, {4'b1101, 5'b00000}, {4'b1001, 5'b00000}, {4'b1111, 5'b00000}
    };

    logic [15:0] cap_word;
    logic p_irq, p_wake, a_irq, a_wake, oe_in, oe_out;
    logic [7:0] dr_out;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic load_ir(input logic [3:0] code);
        logic [15:0] bits;
        bits = {code, 12'hFFF};
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        oe_in = tdo_oe;
        for (int i = 0; i < 16; i++) begin
            cap_word[i] = tdo;
            step(i == 15, bits[i]);
        end
        oe_out = tdo_oe;
        step(1'b1, 1'b0);
        p_irq = dbg_irq_o;
        p_wake = wake_o;
        step(1'b0, 1'b0);
        a_irq = dbg_irq_o;
        a_wake = wake_o;
    endtask

    task automatic shift_dr(input logic [7:0] pat);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            dr_out[i] = tdo;
            step(i == 7, pat[i]);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge tck);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [3:0] prev;
        repeat (3) @(negedge tck);
        #1;
        // R10 / R6 / R3 reset state
        chk("R10 reset oe", tdo_oe, 0);
        chk("R6 reset rst", dbg_rst_o, 0);
        chk("R7 reset irq", dbg_irq_o, 0);
        chk("R8 reset wake", wake_o, 0);
        chk("R3 reset selects bypass", bsr_sel_o, 0);
        trst_n = 1'b1;
        step(1'b0, 1'b0);

        prev = 4'hF;
        for (int k = 0; k < 16; k++) begin
            logic [8:0] v;
            v = VEC[k];
            load_ir(v[8:5]);
            chk("R2 capture word", cap_word, {prev, 12'hFFD});
            chk("R10 oe in Shift-IR", oe_in, 1);
            chk("R10 oe after Exit1-IR", oe_out, 0);
            chk("R6 R9 rst level", dbg_rst_o, v[4]);
            chk("R7 R9 irq at update", p_irq, v[3]);
            chk("R8 R9 wake at update", p_wake, v[2]);
            chk("R7 irq one period", a_irq, 0);
            chk("R8 wake one period", a_wake, 0);
            chk("R5 R4 boundary select", bsr_sel_o, v[1]);
            chk("R5 extest", bsr_extest_o, v[0]);
            prev = v[8:5];
        end

        // R4 bypass path under code 1111
        shift_dr(8'b1011_0110);
        chk("R4 bypass shift", dr_out, {7'b0110110, 1'b0});

        // R4 bypass path under a reserved code (R9)
        load_ir(4'b1101);
        shift_dr(8'b0101_1001);
        chk("R9 R4 reserved uses bypass", dr_out, {7'b1011001, 1'b0});

        // R5 boundary path and strobes
        load_ir(4'b0111);
        load_ir(4'b0000);
        bsr_so_i = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R5 capture strobe", bsr_capture_o, 1);
        step(1'b0, 1'b0);
        chk("R5 shift strobe", bsr_shift_o, 1);
        chk("R5 tdo follows boundary", tdo, 1);
        chk("R10 oe in Shift-DR", tdo_oe, 1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R5 update strobe", bsr_update_o, 1);
        step(1'b0, 1'b0);
        bsr_so_i = 1'b0;

        // R1 five TMS-high clocks from Shift-DR reach Test-Logic-Reset; R3 code returns to bypass
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk("R1 R3 extest cleared by TLR", bsr_extest_o, 0);
        chk("R6 rst kept through TLR", dbg_rst_o, 1);
        chk("R10 oe low in TLR", tdo_oe, 0);
        step(1'b0, 1'b0);
        load_ir(4'b1111);
        chk("R3 code after TLR", cap_word, 16'hFFFD);

        // R6 R1 asynchronous TRST
        load_ir(4'b0000);
        trst_n = 1'b0;
        #2;
        chk("R6 TRST clears rst", dbg_rst_o, 0);
        chk("R1 R3 TRST clears extest", bsr_extest_o, 0);
        @(negedge tck);
        #1;
        trst_n = 1'b1;
        step(1'b0, 1'b0);
        load_ir(4'b1111);
        chk("R3 code after TRST", cap_word, 16'hFFFD);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule